// File: doc/BRIEF.md
# PHY Management Register Bank

This block is the register file behind the management port of an Ethernet PHY core. A request channel with a 5-bit address and 16-bit data carries reads and writes. Read results come back on a response channel one cycle after the request is taken. A test register at the top address holds one enable bit. That bit moves the address window 18h–1Eh from the ordinary register set over to a separate shadow set of seven words. The test register itself never moves.

A control register holds three bits. The first isolates the data path. The second enables auto-negotiation. The third is a self-clearing restart. A read-only status register reports auto-negotiation progress, which is driven by event strobes and levels from the arbitration logic outside this block. Its bits are a live ability-detect level, two sticky acknowledge flags with different clear rules, and a latched-low link indication that re-arms when it is read. While isolation is set, the block blanks the transmit inputs, disables the receive output drivers and holds off link-pulse requests.

Request back-pressure works as follows. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is held that the consumer is not taking in that cycle. A response stays valid, with stable data, until `rsp_ready` is seen high. Writes produce no response.

Top module: `phy_mgmt_regs`

## Requirements
- R1: A read accepted at a clock edge gives `rsp_valid`=1 after that edge. The response holds `rsp_valid` and `rsp_data` stable until a cycle with `rsp_ready`=1. `req_ready` equals `!rsp_valid || rsp_ready`.
- R2: The test register at address 1Fh reads as 000Bh with bit 7 replaced by the shadow enable. The shadow enable resets to 0. Only bit 7 of a write to this register is stored.
- R3: When the shadow enable is 1, addresses 18h–1Eh read and write a separate 7-word shadow set, which resets to 0. When the enable is 0, the same addresses reach the ordinary registers, and the shadow contents are left as they were.
- R4: Address 1Fh reaches the test register whatever the shadow enable holds.
- R5: Every address other than 10h, 11h and 1Fh (and 18h–1Eh while the shadow enable is set) is a plain 16-bit read/write register that resets to 0.
- R6: The control register is at 10h. Bit 0 is isolate (resets to 0) and bit 1 is auto-negotiation enable (resets to 1). Writing 1 to bit 2 drives `an_restart_o` high for the cycle of the write, and bit 2 always reads 0. The other bits read 0.
- R7: The status register at 11h is read-only. A write to it changes no bit of it.
- R8: Status bit 0 reads `ability_state_i` as it stands in the cycle the read is accepted.
- R9: Status bit 1 sets after an `ack_det_exit_i` strobe. It clears only on a restart, so a link fault or a disable leaves it set.
- R10: Status bit 2 sets after an `ack_cmp_exit_i` strobe. It clears on a restart, on a `link_fault_i` strobe, or in any cycle where auto-negotiation is disabled.
- R11: When a set strobe and a clear condition for the same status bit arrive in the same cycle, the bit ends up 0.
- R12: Status bit 3 goes to 0 in any cycle with `link_up_i`=0 and resets to 0. A read of 11h returns the value held before the read. The bit is then set to 1 if `link_up_i` is 1 in that cycle. Status bits 15:4 read 0.
- R13: While isolate is 1, `txd_o`, `tx_en_o`, `rxd_o`, `rxd_oe` and `lpulse_o` are all 0. While isolate is 0, they pass `txd_i`, `tx_en_i`, `rxd_i`, 1 and `lpulse_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | 16 | Read data |
| ability_state_i | input | 1 | Arbitration is in ability-detect state |
| ack_det_exit_i | input | 1 | Strobe: left acknowledge-detected state |
| ack_cmp_exit_i | input | 1 | Strobe: left acknowledge-complete state |
| link_fault_i | input | 1 | Strobe: link fault |
| link_up_i | input | 1 | Live link level |
| txd_i | input | 4 | Transmit nibble from MAC side |
| tx_en_i | input | 1 | Transmit enable from MAC side |
| txd_o | output | 4 | Transmit nibble to core |
| tx_en_o | output | 1 | Transmit enable to core |
| rxd_i | input | 4 | Receive nibble from core |
| rxd_o | output | 4 | Receive nibble to MAC side |
| rxd_oe | output | 1 | Receive output driver enable |
| lpulse_req_i | input | 1 | Link-pulse request from core |
| lpulse_o | output | 1 | Link-pulse request passed on |
| an_enable_o | output | 1 | Auto-negotiation enable |
| an_restart_o | output | 1 | One-cycle restart pulse |

## Verification
A wrong shadow enable shows only on the next access inside 18h–1Eh, which then returns the other set's word in the cycle after the read is taken. A bad sticky or latched status bit is hidden until 11h is read, so the bench reads status right after each strobe, after each clear condition and after colliding set/clear cycles. A wrong isolate bit or wrong handshake state shows at once in the same cycle. The bench therefore compares every output against its model on every clock.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  // control register bit positions
  localparam int CTRL_ISO  = 0;
  localparam int CTRL_ANEN = 1;
  localparam int CTRL_RST  = 2;

  // status register bit positions
  localparam int STAT_ABIL = 0;
  localparam int STAT_ADET = 1;
  localparam int STAT_ACMP = 2;
  localparam int STAT_LINK = 3;

  typedef enum logic [2:0] {
    SEL_DFLT,
    SEL_SHAD,
    SEL_TEST,
    SEL_CTRL,
    SEL_STAT
  } sel_e;

endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int SHADOW_LO = 24,
  parameter int SHADOW_HI = 30,
  parameter int TEST_ADDR = 31,
  parameter int CTRL_ADDR = 16,
  parameter int STAT_ADDR = 17
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              shadow_en,
  output sel_e              sel,
  output logic [ADDR_W-1:0] shadow_off
);

  logic in_window;

  always_comb begin
    in_window  = (addr >= ADDR_W'(SHADOW_LO)) && (addr <= ADDR_W'(SHADOW_HI));
    shadow_off = addr - ADDR_W'(SHADOW_LO);
    // test register first: it is never remapped
    if (addr == ADDR_W'(TEST_ADDR))        sel = SEL_TEST;
    else if (shadow_en && in_window)       sel = SEL_SHAD;
    else if (addr == ADDR_W'(CTRL_ADDR))   sel = SEL_CTRL;
    else if (addr == ADDR_W'(STAT_ADDR))   sel = SEL_STAT;
    else                                   sel = SEL_DFLT;
  end

endmodule

// File: rtl/phy_mgmt_bank.sv
module phy_mgmt_bank #(
  parameter int DEPTH  = 7,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] ridx,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (we && (widx == ADDR_W'(g)))
        mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx == ADDR_W'(i)) rdata = mem[i];
    end
  end

endmodule

// File: rtl/phy_mgmt_status.sv
module phy_mgmt_status
  import phy_mgmt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ability_i,
  input  logic              ack_det_exit_i,
  input  logic              ack_cmp_exit_i,
  input  logic              link_fault_i,
  input  logic              link_up_i,
  input  logic              an_enable_i,
  input  logic              restart_i,
  input  logic              stat_rd_i,
  output logic [DATA_W-1:0] stat_word
);

  logic adet_q, acmp_q, link_ll_q;
  logic acmp_clr;

  assign acmp_clr = restart_i | link_fault_i | ~an_enable_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adet_q    <= 1'b0;
      acmp_q    <= 1'b0;
      link_ll_q <= 1'b0;
    end else begin
      // clear conditions outrank the set strobes
      adet_q <= restart_i ? 1'b0 : (adet_q | ack_det_exit_i);
      acmp_q <= acmp_clr  ? 1'b0 : (acmp_q | ack_cmp_exit_i);
      if (!link_up_i)     link_ll_q <= 1'b0;
      else if (stat_rd_i) link_ll_q <= 1'b1;
    end
  end

  always_comb begin
    stat_word            = '0;
    stat_word[STAT_ABIL] = ability_i;
    stat_word[STAT_ADET] = adet_q;
    stat_word[STAT_ACMP] = acmp_q;
    stat_word[STAT_LINK] = link_ll_q;
  end

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
  import phy_mgmt_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 16,
  parameter int NIB_W     = 4,
  parameter int SHADOW_LO = 24,
  parameter int SHADOW_HI = 30,
  parameter int TEST_ADDR = 31,
  parameter int CTRL_ADDR = 16,
  parameter int STAT_ADDR = 17,
  parameter int SHEN_BIT  = 7,
  parameter logic [DATA_W-1:0] TEST_RSVD = 16'h000B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              ability_state_i,
  input  logic              ack_det_exit_i,
  input  logic              ack_cmp_exit_i,
  input  logic              link_fault_i,
  input  logic              link_up_i,
  input  logic [NIB_W-1:0]  txd_i,
  input  logic              tx_en_i,
  output logic [NIB_W-1:0]  txd_o,
  output logic              tx_en_o,
  input  logic [NIB_W-1:0]  rxd_i,
  output logic [NIB_W-1:0]  rxd_o,
  output logic              rxd_oe,
  input  logic              lpulse_req_i,
  output logic              lpulse_o,
  output logic              an_enable_o,
  output logic              an_restart_o
);

  localparam int DFLT_DEPTH = TEST_ADDR;
  localparam int SHAD_DEPTH = SHADOW_HI - SHADOW_LO + 1;

  logic              acc, wr, rd;
  sel_e              sel;
  logic [ADDR_W-1:0] shadow_off;
  logic              shen_q, iso_q, anen_q;
  logic              restart;
  logic [DATA_W-1:0] dflt_rdata, shad_rdata, stat_word;
  logic [DATA_W-1:0] test_word, ctrl_word, rd_word;
  logic              rv_q;
  logic [DATA_W-1:0] rdata_q;

  // request / response handshake
  assign req_ready = ~rv_q | rsp_ready;
  assign acc       = req_valid & req_ready;
  assign wr        = acc & req_write;
  assign rd        = acc & ~req_write;

  phy_mgmt_decode #(
    .ADDR_W(ADDR_W), .SHADOW_LO(SHADOW_LO), .SHADOW_HI(SHADOW_HI),
    .TEST_ADDR(TEST_ADDR), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_dec (
    .addr      (req_addr),
    .shadow_en (shen_q),
    .sel       (sel),
    .shadow_off(shadow_off)
  );

  phy_mgmt_bank #(.DEPTH(DFLT_DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dflt (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr && (sel == SEL_DFLT)),
    .widx (req_addr),
    .wdata(req_wdata),
    .ridx (req_addr),
    .rdata(dflt_rdata)
  );

  phy_mgmt_bank #(.DEPTH(SHAD_DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shad (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr && (sel == SEL_SHAD)),
    .widx (shadow_off),
    .wdata(req_wdata),
    .ridx (shadow_off),
    .rdata(shad_rdata)
  );

  // test and control registers
  assign restart = wr && (sel == SEL_CTRL) && req_wdata[CTRL_RST];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shen_q <= 1'b0;
      iso_q  <= 1'b0;
      anen_q <= 1'b1;
    end else if (wr) begin
      if (sel == SEL_TEST) shen_q <= req_wdata[SHEN_BIT];
      if (sel == SEL_CTRL) begin
        iso_q  <= req_wdata[CTRL_ISO];
        anen_q <= req_wdata[CTRL_ANEN];
      end
    end
  end

  phy_mgmt_status #(.DATA_W(DATA_W)) u_stat (
    .clk           (clk),
    .rst_n         (rst_n),
    .ability_i     (ability_state_i),
    .ack_det_exit_i(ack_det_exit_i),
    .ack_cmp_exit_i(ack_cmp_exit_i),
    .link_fault_i  (link_fault_i),
    .link_up_i     (link_up_i),
    .an_enable_i   (anen_q),
    .restart_i     (restart),
    .stat_rd_i     (rd && (sel == SEL_STAT)),
    .stat_word     (stat_word)
  );

  // read mux
  always_comb begin
    test_word           = TEST_RSVD;
    test_word[SHEN_BIT] = shen_q;
    ctrl_word            = '0;
    ctrl_word[CTRL_ISO]  = iso_q;
    ctrl_word[CTRL_ANEN] = anen_q;
    case (sel)
      SEL_TEST: rd_word = test_word;
      SEL_SHAD: rd_word = shad_rdata;
      SEL_CTRL: rd_word = ctrl_word;
      SEL_STAT: rd_word = stat_word;
      default:  rd_word = dflt_rdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rv_q    <= 1'b0;
      rdata_q <= '0;
    end else if (rd) begin
      rv_q    <= 1'b1;
      rdata_q <= rd_word;
    end else if (rsp_ready) begin
      rv_q    <= 1'b0;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rdata_q;

  // isolation gating
  assign txd_o        = iso_q ? '0 : txd_i;
  assign tx_en_o      = tx_en_i & ~iso_q;
  assign rxd_o        = iso_q ? '0 : rxd_i;
  assign rxd_oe       = ~iso_q;
  assign lpulse_o     = lpulse_req_i & ~iso_q;
  assign an_enable_o  = anen_q;
  assign an_restart_o = restart;

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              ack_det_exit_i,
  input logic              link_fault_i,
  input logic              link_up_i,
  input logic              an_enable_o,
  input logic              an_restart_o,
  input logic [DATA_W-1:0] stat_word,
  input logic [NIB_W-1:0]  txd_o,
  input logic              tx_en_o,
  input logic              rxd_oe,
  input logic              lpulse_o
);

  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_backpressure_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  assert_test_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_valid && req_ready && !req_write && (req_addr == 5'h1F)))
      |-> (rsp_data[15:8] == 8'h00 && rsp_data[4:0] == 5'h0B));

  assert_adet_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[1] && !an_restart_o) |=> stat_word[1]);

  assert_acmp_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (an_restart_o || link_fault_i || !an_enable_o) |=> !stat_word[2]);

  assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_det_exit_i && an_restart_o) |=> !stat_word[1]);

  assert_link_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up_i |=> !stat_word[3]);

  assert_isolate_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !rxd_oe |-> (txd_o == '0 && !tx_en_o && !lpulse_o));

endmodule

bind phy_mgmt_regs phy_mgmt_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NIB_W(NIB_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_write     (req_write),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .ack_det_exit_i(ack_det_exit_i),
  .link_fault_i  (link_fault_i),
  .link_up_i     (link_up_i),
  .an_enable_o   (an_enable_o),
  .an_restart_o  (an_restart_o),
  .stat_word     (stat_word),
  .txd_o         (txd_o),
  .tx_en_o       (tx_en_o),
  .rxd_oe        (rxd_oe),
  .lpulse_o      (lpulse_o)
);

// File: tb/phy_mgmt_regs_tb.sv
module phy_mgmt_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [4:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        ability_state_i = 0, ack_det_exit_i = 0, ack_cmp_exit_i = 0;
  logic        link_fault_i = 0, link_up_i = 1;
  logic [3:0]  txd_i = 4'h5, rxd_i = 4'hA;
  logic        tx_en_i = 1, lpulse_req_i = 1;
  logic        req_ready, rsp_valid, tx_en_o, rxd_oe, lpulse_o, an_enable_o, an_restart_o;
  logic [15:0] rsp_data;
  logic [3:0]  txd_o, rxd_o;

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  phy_mgmt_regs u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .ability_state_i(ability_state_i), .ack_det_exit_i(ack_det_exit_i),
    .ack_cmp_exit_i(ack_cmp_exit_i), .link_fault_i(link_fault_i), .link_up_i(link_up_i),
    .txd_i(txd_i), .tx_en_i(tx_en_i), .txd_o(txd_o), .tx_en_o(tx_en_o),
    .rxd_i(rxd_i), .rxd_o(rxd_o), .rxd_oe(rxd_oe), .lpulse_req_i(lpulse_req_i),
    .lpulse_o(lpulse_o), .an_enable_o(an_enable_o), .an_restart_o(an_restart_o)
  );

  // behavioural reference model
  logic [15:0] m_dflt [32];
  logic [15:0] m_shad [7];
  bit m_shen, m_iso, m_anen, m_adet, m_acmp, m_ll, m_rv;
  logic [15:0] m_rd;

  function automatic logic [15:0] m_read(input int a);
    if (a == 31) return {8'h00, m_shen, 2'b00, 5'h0B};
    if (m_shen && a >= 24 && a <= 30) return m_shad[a-24];
    if (a == 16) return {13'd0, 1'b0, m_anen, m_iso};
    if (a == 17) return {12'd0, m_ll, m_acmp, m_adet, ability_state_i};
    return m_dflt[a];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) m_dflt[i] = '0;
      for (int i = 0; i < 7; i++) m_shad[i] = '0;
      m_shen = 0; m_iso = 0; m_anen = 1; m_adet = 0; m_acmp = 0; m_ll = 0;
      m_rv = 0; m_rd = '0;
    end else begin
      bit acc, rst_pulse, old_anen;
      int a;
      a = int'(req_addr);
      acc = req_valid && (!m_rv || rsp_ready);
      rst_pulse = acc && req_write && a == 16 && req_wdata[2];
      old_anen = m_anen;
      if (m_rv && rsp_ready) m_rv = 0;
      if (acc && !req_write) begin m_rv = 1; m_rd = m_read(a); end
      if (rst_pulse) m_adet = 0; else if (ack_det_exit_i) m_adet = 1;
      if (rst_pulse || link_fault_i || !old_anen) m_acmp = 0;
      else if (ack_cmp_exit_i) m_acmp = 1;
      if (!link_up_i) m_ll = 0; else if (acc && !req_write && a == 17) m_ll = 1;
      if (acc && req_write) begin
        if (a == 31) m_shen = req_wdata[7];
        else if (m_shen && a >= 24 && a <= 30) m_shad[a-24] = req_wdata;
        else if (a == 16) begin m_iso = req_wdata[0]; m_anen = req_wdata[1]; end
        else if (a != 17) m_dflt[a] = req_wdata;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 req_ready", {15'd0, req_ready}, {15'd0, !m_rv || rsp_ready});
      chk("R1 rsp_valid", {15'd0, rsp_valid}, {15'd0, m_rv});
      if (m_rv) chk("R3 rsp_data", rsp_data, m_rd);
      chk("R13 txd_o", {12'd0, txd_o}, m_iso ? 16'd0 : {12'd0, txd_i});
      chk("R13 tx_en_o", {15'd0, tx_en_o}, {15'd0, tx_en_i && !m_iso});
      chk("R13 rxd_o", {12'd0, rxd_o}, m_iso ? 16'd0 : {12'd0, rxd_i});
      chk("R13 rxd_oe", {15'd0, rxd_oe}, {15'd0, !m_iso});
      chk("R13 lpulse_o", {15'd0, lpulse_o}, {15'd0, lpulse_req_i && !m_iso});
      chk("R6 an_enable_o", {15'd0, an_enable_o}, {15'd0, m_anen});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(posedge clk); #2;
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #2;
    req_valid = 1; req_write = 0; req_addr = a;
    @(posedge clk); #2;
    req_valid = 0;
    @(negedge clk);
    chk({tag, " valid"}, {15'd0, rsp_valid}, 16'd1);
    chk(tag, rsp_data, exp);
  endtask

  task automatic strobe(input int which);
    @(posedge clk); #2;
    case (which)
      0: ack_det_exit_i = 1;
      1: ack_cmp_exit_i = 1;
      default: link_fault_i = 1;
    endcase
    @(posedge clk); #2;
    ack_det_exit_i = 0; ack_cmp_exit_i = 0; link_fault_i = 0;
  endtask

  initial begin
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog act=%0d exp=done", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // reset state
    rd(5'h1F, 16'h000B, "R2 test reset");
    rd(5'h10, 16'h0002, "R6 ctrl reset");
    rd(5'h11, 16'h0000, "R12 link latched after reset");
    rd(5'h11, 16'h0008, "R12 link re-armed");
    // plain registers and window with shadow off
    wr(5'h05, 16'h1234); rd(5'h05, 16'h1234, "R5 plain reg");
    wr(5'h18, 16'hAAAA); rd(5'h18, 16'hAAAA, "R3 window to default");
    // shadow on
    wr(5'h1F, 16'hFFFF); rd(5'h1F, 16'h008B, "R2 only enable bit stored");
    rd(5'h18, 16'h0000, "R3 shadow reset");
    wr(5'h18, 16'h5555); rd(5'h18, 16'h5555, "R3 shadow write");
    wr(5'h1E, 16'h7777); rd(5'h1E, 16'h7777, "R3 shadow top");
    rd(5'h05, 16'h1234, "R5 outside window");
    wr(5'h1F, 16'h0000); rd(5'h1F, 16'h000B, "R4 test reg reachable");
    rd(5'h18, 16'hAAAA, "R3 default kept");
    rd(5'h1E, 16'h0000, "R3 default top untouched");
    wr(5'h1F, 16'h0080); rd(5'h18, 16'h5555, "R3 shadow kept");
    wr(5'h1F, 16'h0000);
    // status register
    wr(5'h11, 16'hFFFF); rd(5'h11, 16'h0008, "R7 status write ignored");
    ability_state_i = 1; rd(5'h11, 16'h0009, "R8 ability live");
    ability_state_i = 0; rd(5'h11, 16'h0008, "R8 ability low");
    strobe(0); rd(5'h11, 16'h000A, "R9 ack detected set");
    strobe(2); rd(5'h11, 16'h000A, "R9 fault keeps ack detected");
    strobe(1); rd(5'h11, 16'h000E, "R10 ack complete set");
    strobe(2); rd(5'h11, 16'h000A, "R10 fault clears ack complete");
    strobe(1); wr(5'h10, 16'h0000); rd(5'h11, 16'h000A, "R10 disable clears");
    strobe(1); rd(5'h11, 16'h000A, "R11 set while disabled");
    rd(5'h10, 16'h0000, "R6 enable cleared");
    wr(5'h10, 16'h0002); strobe(1); rd(5'h11, 16'h000E, "R10 set again");
    wr(5'h10, 16'h0006); rd(5'h11, 16'h0008, "R9 restart clears");
    rd(5'h10, 16'h0002, "R6 restart self-clears");
    // set and restart in the same cycle
    @(posedge clk); #2;
    ack_det_exit_i = 1; ack_cmp_exit_i = 1;
    req_valid = 1; req_write = 1; req_addr = 5'h10; req_wdata = 16'h0006;
    @(negedge clk); chk("R6 restart pulse", {15'd0, an_restart_o}, 16'd1);
    @(posedge clk); #2;
    ack_det_exit_i = 0; ack_cmp_exit_i = 0; req_valid = 0; req_write = 0;
    rd(5'h11, 16'h0008, "R11 clear beats set");
    // latched-low link
    @(posedge clk); #2 link_up_i = 0;
    @(posedge clk); #2 link_up_i = 1;
    rd(5'h11, 16'h0000, "R12 link drop latched");
    rd(5'h11, 16'h0008, "R12 link after read");
    // isolation
    wr(5'h10, 16'h0003);
    @(negedge clk);
    chk("R13 isolated oe", {15'd0, rxd_oe}, 16'd0);
    chk("R13 isolated lpulse", {15'd0, lpulse_o}, 16'd0);
    chk("R13 isolated txd", {12'd0, txd_o}, 16'd0);
    wr(5'h10, 16'h0002);
    @(negedge clk);
    chk("R13 released rxd", {12'd0, rxd_o}, 16'h000A);
    // back-pressure
    @(posedge clk); #2;
    rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 5'h05;
    @(posedge clk); #2;
    req_addr = 5'h18;
    @(negedge clk);
    chk("R1 held valid", {15'd0, rsp_valid}, 16'd1);
    chk("R1 ready low", {15'd0, req_ready}, 16'd0);
    @(posedge clk); #2;
    @(negedge clk);
    chk("R1 held data", rsp_data, 16'h1234);
    @(posedge clk); #2 rsp_ready = 1;
    @(posedge clk); #2 req_valid = 0;
    @(negedge clk);
    chk("R1 next read", rsp_data, 16'hAAAA);
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule